// File: doc/BRIEF.md
# Host-to-ISA I/O Window Bridge

This bridge sits between a CPU-side request/response bus and an ISA-style port bus. CPU accesses that land in an 8 MB I/O window at 0x80000000 become single port cycles. The port address is formed in one of two ways, chosen by a map-mode input. In flat mode the low 16 address bits are used. In sparse mode, address bits 22..12 fold down into port bits 15..5, and bits 4..0 pass straight through.

When the CPU is big-endian (a parameter), multi-byte data is byte-swapped in both directions, so that little-endian peripherals appear correct to the CPU.

A separate four-byte window at 0xBFFFFFF0 handles interrupt acknowledge. A read at offset zero returns the vector from the interrupt controller and pulses an acknowledge strobe toward it. Any access outside both windows is answered at once with a miss flag and read data of all ones.

Top module: `isa_io_bridge`

## Requirements
- R1: A CPU request whose address bits 31..23 equal 9'h100 produces a one-cycle `io_req` in the cycle after acceptance. `cpu_done` rises exactly one cycle after `io_done` is sampled high, and not before.
- R2: With `map_sparse` = 0, `io_addr` equals `cpu_addr[15:0]`.
- R3: With `map_sparse` = 1, `io_addr` equals {`cpu_addr[22:12]`, `cpu_addr[4:0]`}. CPU address bits 11..5 are discarded.
- R4: With BIG_ENDIAN = 1, write data is transformed according to `cpu_size` before it reaches `io_wdata`. Size 0 is a byte and passes unchanged. Size 1 is a halfword, and its bytes [7:0] and [15:8] are exchanged while bits 31..16 pass unchanged. Size 2 is a word and is fully byte-reversed.
- R5: With BIG_ENDIAN = 1, read data from `io_rdata` receives the same transform as in R4, keyed by the size of the access, before it appears on `cpu_rdata`.
- R6: Only one transaction is outstanding at a time. A `cpu_req` that arrives while a port cycle is pending is ignored, and produces neither `io_req` nor `cpu_done`. `cpu_done` is a one-cycle pulse.
- R7: A read at 0xBFFFFFF0 completes in the next cycle. It returns the zero-extended `irq_vector`, passed through the R4 transform, and `irq_ack` pulses high for that single cycle.
- R8: A read at 0xBFFFFFF1..0xBFFFFFF3 returns 0 and does not pulse `irq_ack`.
- R9: A write anywhere in 0xBFFFFFF0..0xBFFFFFF3 completes in the next cycle. It has no effect: no `irq_ack`, no `io_req`, and no miss.
- R10: An access outside both windows completes in the next cycle with `cpu_miss` = 1 and `cpu_rdata` = 32'hFFFFFFFF, and issues no `io_req`.
- R11: With BIG_ENDIAN = 0, data passes in both directions unchanged at every size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, one cycle |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, valid with cpu_done |
| cpu_done | output | 1 | Access complete, one-cycle pulse |
| cpu_miss | output | 1 | Access hit neither window |
| map_sparse | input | 1 | 0 flat 64 KB map, 1 sparse 8 MB map |
| io_req | output | 1 | Port cycle start, one cycle |
| io_we | output | 1 | Port cycle is a write |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port access size |
| io_wdata | output | 32 | Port write data |
| io_rdata | input | 32 | Port read data, valid with io_done |
| io_done | input | 1 | Port cycle complete |
| irq_vector | input | VEC_W | Vector from interrupt controller |
| irq_ack | output | 1 | Acknowledge strobe to interrupt controller |

## Verification
The hardest case to reach is a second CPU request that arrives while a port cycle is still pending. The bench sets this up by holding back `io_done` and then pulsing `cpu_req` toward a different window in the middle of the wait. It then checks that no second port cycle and no early completion appear.

The sparse map is driven with addresses that have bits 11..5 set, so that a fold that kept those bits would show up at once. A little-endian instance shares every stimulus with the big-endian one, which makes the absence of swapping visible on the same accesses.

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
  parameter bit          BIG_ENDIAN   = 1'b1,
  parameter int          VEC_W        = 8,
  parameter logic [31:0] IO_BASE      = 32'h8000_0000,
  parameter int          IO_SPAN_LOG2 = 23,
  parameter logic [31:0] ACK_BASE     = 32'hBFFF_FFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [31:0]      cpu_addr,
  input  logic [1:0]       cpu_size,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_done,
  output logic             cpu_miss,
  input  logic             map_sparse,
  output logic             io_req,
  output logic             io_we,
  output logic [15:0]      io_addr,
  output logic [1:0]       io_size,
  output logic [31:0]      io_wdata,
  input  logic [31:0]      io_rdata,
  input  logic             io_done,
  input  logic [VEC_W-1:0] irq_vector,
  output logic             irq_ack
);
  localparam int TAG_W = 32 - IO_SPAN_LOG2;

  function automatic logic [31:0] order(input logic [31:0] d, input logic [1:0] sz);
    if (!BIG_ENDIAN || sz == 2'd0) return d;
    if (sz == 2'd1) return {d[31:16], d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  logic        busy;
  logic        accept;
  logic        in_io, in_ack;
  logic [15:0] port_addr;
  logic [31:0] vec_word;

  assign accept    = cpu_req && !busy;
  assign in_io     = cpu_addr[31:IO_SPAN_LOG2] == IO_BASE[31:IO_SPAN_LOG2];
  assign in_ack    = cpu_addr[31:2] == ACK_BASE[31:2];
  assign port_addr = map_sparse ? {cpu_addr[22:12], cpu_addr[4:0]} : cpu_addr[15:0];
  assign vec_word  = {{(32-VEC_W){1'b0}}, irq_vector};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      io_req    <= 1'b0;
      io_we     <= 1'b0;
      io_addr   <= '0;
      io_size   <= '0;
      io_wdata  <= '0;
      cpu_done  <= 1'b0;
      cpu_miss  <= 1'b0;
      cpu_rdata <= '0;
      irq_ack   <= 1'b0;
    end else begin
      io_req   <= 1'b0;
      cpu_done <= 1'b0;
      cpu_miss <= 1'b0;
      irq_ack  <= 1'b0;
      if (busy) begin
        if (io_done) begin
          busy      <= 1'b0;
          cpu_done  <= 1'b1;
          cpu_rdata <= order(io_rdata, io_size);
        end
      end else if (accept) begin
        if (in_io) begin
          busy     <= 1'b1;
          io_req   <= 1'b1;
          io_we    <= cpu_we;
          io_addr  <= port_addr;
          io_size  <= cpu_size;
          io_wdata <= order(cpu_wdata, cpu_size);
        end else if (in_ack) begin
          cpu_done <= 1'b1;
          if (!cpu_we) begin
            cpu_rdata <= (cpu_addr[3:0] == 4'd0) ? order(vec_word, cpu_size) : 32'd0;
            irq_ack   <= (cpu_addr[3:0] == 4'd0);
          end
        end else begin
          cpu_done  <= 1'b1;
          cpu_miss  <= 1'b1;
          cpu_rdata <= 32'hFFFF_FFFF;
        end
      end
    end
  end

  p_io_req_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |=> !io_req);
  p_done_follows_io_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && io_done) |=> cpu_done);
  p_no_done_at_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> !cpu_done);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !io_done) |=> (!io_req && !cpu_done));
  p_ack_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (cpu_done && !cpu_miss));
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  p_ack_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_ack && cpu_we) |=> (!irq_ack && !io_req && !cpu_miss && cpu_done));
  p_miss_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_miss |-> (cpu_done && cpu_rdata == 32'hFFFF_FFFF && !io_req));
endmodule

// File: tb/test_isa_io_bridge.sv
`timescale 1ns/1ps
module test_isa_io_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0, map_sparse = 0, io_done = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, io_rdata = 0;
  logic [1:0]  cpu_size = 0;
  logic [7:0]  irq_vector = 8'h2A;

  logic [31:0] cpu_rdata, le_rdata, io_wdata, le_wdata;
  logic        cpu_done, cpu_miss, io_req, io_we, irq_ack;
  logic        le_done, le_miss, le_req, le_we, le_ack;
  logic [15:0] io_addr, le_addr;
  logic [1:0]  io_size, le_size;

  isa_io_bridge i_isa_io_bridge (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_size, .cpu_wdata,
    .cpu_rdata, .cpu_done, .cpu_miss, .map_sparse, .io_req, .io_we, .io_addr,
    .io_size, .io_wdata, .io_rdata, .io_done, .irq_vector, .irq_ack);

  isa_io_bridge #(.BIG_ENDIAN(1'b0)) i_isa_io_bridge_le (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_size, .cpu_wdata,
    .cpu_rdata(le_rdata), .cpu_done(le_done), .cpu_miss(le_miss), .map_sparse,
    .io_req(le_req), .io_we(le_we), .io_addr(le_addr), .io_size(le_size),
    .io_wdata(le_wdata), .io_rdata, .io_done, .irq_vector, .irq_ack(le_ack));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic        sp;
    logic [31:0] wd;
    logic [31:0] iord;
    logic [15:0] eaddr;
    logic [31:0] ewd;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h8000_03F8, 2'd0, 1'b0, 32'h0000_00A5, 32'h0, 16'h03F8, 32'h0000_00A5, 32'h0},
    '{1'b1, 32'h8000_1234, 2'd1, 1'b0, 32'h0000_1122, 32'h0, 16'h1234, 32'h0000_2211, 32'h0},
    '{1'b1, 32'h8012_ABCD, 2'd2, 1'b0, 32'h1122_3344, 32'h0, 16'hABCD, 32'h4433_2211, 32'h0},
    '{1'b0, 32'h8000_0060, 2'd0, 1'b0, 32'h0, 32'h0000_005A, 16'h0060, 32'h0, 32'h0000_005A},
    '{1'b0, 32'h8000_0170, 2'd1, 1'b0, 32'h0, 32'h0000_BEEF, 16'h0170, 32'h0, 32'h0000_EFBE},
    '{1'b0, 32'h8000_0CF8, 2'd2, 1'b0, 32'h0, 32'hDEAD_BEEF, 16'h0CF8, 32'h0, 32'hEFBE_ADDE},
    '{1'b1, 32'h807F_F01F, 2'd0, 1'b1, 32'h0000_003C, 32'h0, 16'hFFFF, 32'h0000_003C, 32'h0},
    '{1'b0, 32'h8000_3FE4, 2'd2, 1'b1, 32'h0, 32'h0102_0304, 16'h0064, 32'h0, 32'h0403_0201},
    '{1'b0, 32'h8039_8005, 2'd1, 1'b1, 32'h0, 32'h0000_CAFE, 16'h7305, 32'h0, 32'h0000_FECA},
    '{1'b0, 32'h807F_FFFF, 2'd0, 1'b0, 32'h0, 32'h0000_0077, 16'hFFFF, 32'h0, 32'h0000_0077}
  };

  task automatic drive(input logic we, input logic [31:0] a, input logic [1:0] sz,
                       input logic sp, input logic [31:0] wd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_size = sz; map_sparse = sp; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic io_access(input vec_t v);
    drive(v.we, v.addr, v.size, v.sp, v.wd);
    chk("R1 io_req", io_req, 1);
    chk("R1 done early", cpu_done, 0);
    chk("R1 io_we", io_we, v.we);
    chk(v.sp ? "R3 io_addr" : "R2 io_addr", io_addr, v.eaddr);
    if (v.we) begin
      chk("R4 io_wdata", io_wdata, v.ewd);
      chk("R11 le wdata", le_wdata, v.wd);
    end
    @(negedge clk);
    chk("R1 req pulse", io_req, 0);
    chk("R1 wait no done", cpu_done, 0);
    io_done = 1; io_rdata = v.iord;
    @(posedge clk);
    @(negedge clk);
    io_done = 0;
    chk("R1 done", cpu_done, 1);
    chk("R10 no miss", cpu_miss, 0);
    chk("R5 cpu_rdata", cpu_rdata, v.erd);
    chk("R11 le rdata", le_rdata, v.iord);
    @(negedge clk);
    chk("R6 done pulse", cpu_done, 0);
  endtask

  task automatic direct(input string req, input logic we, input logic [31:0] a,
                        input logic [1:0] sz, input logic [31:0] erd,
                        input logic emiss, input logic eack);
    drive(we, a, sz, 1'b0, 32'h5555_AAAA);
    chk({req, " done"}, cpu_done, 1);
    chk({req, " miss"}, cpu_miss, emiss);
    chk({req, " ack"}, irq_ack, eack);
    chk({req, " no io_req"}, io_req, 0);
    if (!we) chk({req, " rdata"}, cpu_rdata, erd);
    @(negedge clk);
    chk({req, " ack pulse"}, irq_ack, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset io_req", io_req, 0);
    chk("R6 reset done", cpu_done, 0);
    chk("R10 reset miss", cpu_miss, 0);
    chk("R7 reset ack", irq_ack, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) io_access(TBL[i]);

    direct("R7 byte", 1'b0, 32'hBFFF_FFF0, 2'd0, 32'h0000_002A, 1'b0, 1'b1);
    chk("R11 le ack byte", le_rdata, 32'h0000_002A);
    direct("R7 half", 1'b0, 32'hBFFF_FFF0, 2'd1, 32'h0000_2A00, 1'b0, 1'b1);
    chk("R11 le ack half", le_rdata, 32'h0000_002A);
    irq_vector = 8'h81;
    direct("R7 word", 1'b0, 32'hBFFF_FFF0, 2'd2, 32'h8100_0000, 1'b0, 1'b1);
    direct("R8 offset2", 1'b0, 32'hBFFF_FFF2, 2'd0, 32'h0, 1'b0, 1'b0);
    direct("R8 offset3", 1'b0, 32'hBFFF_FFF3, 2'd0, 32'h0, 1'b0, 1'b0);
    direct("R9 ack write", 1'b1, 32'hBFFF_FFF0, 2'd0, 32'h0, 1'b0, 1'b0);
    chk("R9 rdata kept", cpu_rdata, 32'h0);
    direct("R10 above", 1'b0, 32'h8080_0000, 2'd2, 32'hFFFF_FFFF, 1'b1, 1'b0);
    direct("R10 below", 1'b0, 32'h7FFF_FFFF, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    direct("R10 past ack", 1'b0, 32'hBFFF_FFF4, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    direct("R10 before ack", 1'b1, 32'hBFFF_FFEF, 2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);

    // R6: request arriving mid-transaction is dropped
    drive(1'b0, 32'h8000_0092, 2'd0, 1'b0, 32'h0);
    chk("R6 first req", io_req, 1);
    @(negedge clk);
    cpu_req = 1; cpu_addr = 32'hBFFF_FFF0; cpu_we = 0;
    @(negedge clk);
    cpu_req = 1; cpu_addr = 32'h8000_0400;
    @(negedge clk);
    cpu_req = 0;
    chk("R6 busy no io_req", io_req, 0);
    chk("R6 busy no done", cpu_done, 0);
    chk("R6 busy no ack", irq_ack, 0);
    io_done = 1; io_rdata = 32'h0000_0011;
    @(negedge clk);
    io_done = 0;
    chk("R6 done", cpu_done, 1);
    chk("R6 rdata", cpu_rdata, 32'h0000_0011);
    @(negedge clk);
    chk("R6 idle no io_req", io_req, 0);
    chk("R6 done once", cpu_done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule